// File: doc/BRIEF.md
# Hybrid Skewed Branch Direction Predictor

This block predicts whether a conditional branch is taken. It reads four tables of 2-bit counters. The first is a small bimodal table that needs little history. The next two are skewed global tables, each indexed with a different length of global history. The last is a chooser table. When the chooser bit is 0 the final prediction is the bimodal bit. When it is 1 the final prediction is the majority vote of the bimodal bit and the two skewed bits. The fetch logic presents a lookup with the branch address and a global history vector. One cycle later the block returns the final direction, the four component bits and the four table indices.

When the branch resolves, the pipeline sends back the indices and component bits it kept from the lookup, together with the real outcome. No table is read again to rebuild them. Each counter is split into a prediction bit, held in a prediction array, and a hysteresis bit, held in a separate hysteresis array. Two adjacent prediction entries may share one hysteresis bit. Updates are partial:
- A correct prediction only strengthens hysteresis bits.
- A wrong prediction reads the hysteresis bit and may rewrite the prediction bit.

Top module: `skew_bp`

## Requirements
- R1: Reset sets every prediction bit and every hysteresis bit to 0, which is the weakly not-taken state. `out_valid` is 0 while `rst` is high. The first lookup of any address after reset returns 0 on all four component bits and on `out_taken`.
- R2: The outputs of a lookup presented with `lk_valid` high are due one clock edge later, and `out_valid` is 1 in that cycle. `out_valid` is 0 in the cycle after an edge at which `lk_valid` was low.
- R3: Each table index is `pc[W-1:0]` XOR a fold of `hist[L-1:0]`, where history bit i flips index bit (i mod W). The bimodal table uses W = 6 and L = 4. G0 uses W = 8 and L = 13. G1 uses W = 8 and L = 21. The chooser uses W = 8 and L = 17.
- R4: `out_taken` equals `out_meta ? majority(out_bim, out_g0, out_g1) : out_bim`.
- R5: On a correct final prediction no prediction bit is written. If the chooser picked the majority, each of bimodal, G0 and G1 whose bit matched the outcome gets its hysteresis bit set to 1. If the chooser picked the bimodal bit, only the bimodal hysteresis bit is set.
- R6: On a wrong final prediction, bimodal, G0 and G1 each step toward the outcome. A component whose bit matched the outcome gets its hysteresis set. A component whose bit was wrong with hysteresis 1 has its hysteresis cleared and keeps its prediction bit. A component whose bit was wrong with hysteresis 0 takes the outcome as its new prediction bit.
- R7: The chooser is touched only when the bimodal bit and the majority differ. Its target is 1 when the majority matched the outcome and 0 otherwise, and it follows the same step rule as R6. When the two agree, the chooser is left unchanged.
- R8: G0 and the chooser share one hysteresis bit between the two entries whose indices differ only in bit 0. Bimodal and G1 have one hysteresis bit per entry. Prediction bits are never shared.
- R9: An update accepted at one clock edge is seen by a lookup presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 16 | Branch address for the lookup |
| lk_hist | input | 24 | Global history for the lookup, bit 0 newest |
| out_valid | output | 1 | Lookup result valid |
| out_taken | output | 1 | Final predicted direction |
| out_bim | output | 1 | Bimodal prediction bit |
| out_g0 | output | 1 | G0 prediction bit |
| out_g1 | output | 1 | G1 prediction bit |
| out_meta | output | 1 | Chooser bit (1 selects majority) |
| out_idx_bim | output | 6 | Bimodal index used |
| out_idx_g0 | output | 8 | G0 index used |
| out_idx_g1 | output | 8 | G1 index used |
| out_idx_meta | output | 8 | Chooser index used |
| up_valid | input | 1 | Resolved-branch update |
| up_taken | input | 1 | Actual branch outcome |
| up_bim | input | 1 | Bimodal bit seen at lookup |
| up_g0 | input | 1 | G0 bit seen at lookup |
| up_g1 | input | 1 | G1 bit seen at lookup |
| up_meta | input | 1 | Chooser bit seen at lookup |
| up_idx_bim | input | 6 | Bimodal index from the lookup |
| up_idx_g0 | input | 8 | G0 index from the lookup |
| up_idx_g1 | input | 8 | G1 index from the lookup |
| up_idx_meta | input | 8 | Chooser index from the lookup |

## Verification
A lookup's direction, component bits and indices are due one edge after `lk_valid` is sampled. The bench drives each request on a falling edge and samples on the next falling edge, half a cycle after that register has loaded. An update writes the tables at the single rising edge it spans, so its effect is checked with a lookup issued in the very next cycle. Training sequences check every counter transition through the component bits returned by these lookups.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_STRONG = 2'd1,
        UPD_STEP   = 2'd2
    } upd_mode_e;

    typedef struct packed {
        logic bim;
        logic g0;
        logic g1;
        logic meta;
    } comp_bits_t;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Address low bits XOR the folded first hlen history bits.
    function automatic logic [31:0] fold_index(input logic [31:0] pc,
                                               input logic [31:0] hist,
                                               input int unsigned hlen,
                                               input int unsigned w);
        logic [31:0] idx;
        idx = pc & ((32'd1 << w) - 32'd1);
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < hlen) idx[i % w] = idx[i % w] ^ hist[i];
        end
        return idx;
    endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int SHARE_LG = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  upd_mode_e        up_mode,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_p,
    input  logic             up_dir
);
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int H_W       = IDX_W - SHARE_LG;
    localparam int H_ENTRIES = 1 << H_W;

    logic [ENTRIES-1:0]   pred_q;
    logic [H_ENTRIES-1:0] hyst_q;
    logic [H_W-1:0]       hidx;

    assign hidx   = up_idx[IDX_W-1:SHARE_LG];
    assign rd_bit = pred_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            hyst_q <= '0;
        end else if (up_mode == UPD_STRONG) begin
            hyst_q[hidx] <= 1'b1;
        end else if (up_mode == UPD_STEP) begin
            if (up_p == up_dir)    hyst_q[hidx]   <= 1'b1;
            else if (hyst_q[hidx]) hyst_q[hidx]   <= 1'b0;
            else                   pred_q[up_idx] <= up_dir;
        end
    end

    // R5: a strengthening write leaves the prediction bit alone
    a_r5_strong_keeps_pred: assert property (@(posedge clk) disable iff (rst)
        (up_mode == UPD_STRONG) |=> pred_q[$past(up_idx)] == $past(pred_q[up_idx]));

    // R6: a wrong, strong counter keeps its prediction bit
    a_r6_strong_holds: assert property (@(posedge clk) disable iff (rst)
        (up_mode == UPD_STEP && up_p != up_dir && hyst_q[hidx])
        |=> pred_q[$past(up_idx)] == $past(pred_q[up_idx]) && !hyst_q[$past(hidx)]);

    // R6: a wrong, weak counter adopts the outcome
    a_r6_weak_flips: assert property (@(posedge clk) disable iff (rst)
        (up_mode == UPD_STEP && up_p != up_dir && !hyst_q[hidx])
        |=> pred_q[$past(up_idx)] == $past(up_dir));

endmodule

// File: rtl/bp_update_ctl.sv
module bp_update_ctl
    import bp_pkg::*;
(
    input  logic       up_valid,
    input  logic       up_taken,
    input  comp_bits_t seen,
    output upd_mode_e  mode_bim,
    output upd_mode_e  mode_g0,
    output upd_mode_e  mode_g1,
    output upd_mode_e  mode_meta,
    output logic       meta_dir
);
    logic maj, final_dir, correct;

    assign maj       = majority3(seen.bim, seen.g0, seen.g1);
    assign final_dir = seen.meta ? maj : seen.bim;
    assign correct   = (final_dir == up_taken);
    assign meta_dir  = (maj == up_taken);

    always_comb begin
        mode_bim  = UPD_NONE;
        mode_g0   = UPD_NONE;
        mode_g1   = UPD_NONE;
        mode_meta = UPD_NONE;
        if (up_valid) begin
            if (correct) begin
                if (seen.meta) begin
                    if (seen.bim == up_taken) mode_bim = UPD_STRONG;
                    if (seen.g0  == up_taken) mode_g0  = UPD_STRONG;
                    if (seen.g1  == up_taken) mode_g1  = UPD_STRONG;
                end else begin
                    mode_bim = UPD_STRONG;
                end
            end else begin
                mode_bim = UPD_STEP;
                mode_g0  = UPD_STEP;
                mode_g1  = UPD_STEP;
            end
            if (seen.bim != maj) mode_meta = correct ? UPD_STRONG : UPD_STEP;
        end
    end

    // R5: a correct prediction never requests a step
    always_comb begin
        if (up_valid && ((seen.meta ? majority3(seen.bim, seen.g0, seen.g1) : seen.bim) == up_taken))
            a_r5_no_step: assert (mode_bim != UPD_STEP && mode_g0 != UPD_STEP &&
                                  mode_g1 != UPD_STEP && mode_meta != UPD_STEP);
    end

    // R7: chooser idle when bimodal and majority agree
    always_comb begin
        if (seen.bim == majority3(seen.bim, seen.g0, seen.g1))
            a_r7_meta_idle: assert (mode_meta == UPD_NONE);
    end

endmodule

// File: rtl/skew_bp.sv
module skew_bp
    import bp_pkg::*;
#(
    parameter int PC_W          = 16,
    parameter int HIST_W        = 24,
    parameter int BIM_IDX_W     = 6,
    parameter int TAB_IDX_W     = 8,
    parameter int BIM_HIST      = 4,
    parameter int G0_HIST       = 13,
    parameter int G1_HIST       = 21,
    parameter int META_HIST     = 17,
    parameter int BIM_SHARE_LG  = 0,
    parameter int G0_SHARE_LG   = 1,
    parameter int G1_SHARE_LG   = 0,
    parameter int META_SHARE_LG = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [PC_W-1:0]      lk_pc,
    input  logic [HIST_W-1:0]    lk_hist,
    output logic                 out_valid,
    output logic                 out_taken,
    output logic                 out_bim,
    output logic                 out_g0,
    output logic                 out_g1,
    output logic                 out_meta,
    output logic [BIM_IDX_W-1:0] out_idx_bim,
    output logic [TAB_IDX_W-1:0] out_idx_g0,
    output logic [TAB_IDX_W-1:0] out_idx_g1,
    output logic [TAB_IDX_W-1:0] out_idx_meta,
    input  logic                 up_valid,
    input  logic                 up_taken,
    input  logic                 up_bim,
    input  logic                 up_g0,
    input  logic                 up_g1,
    input  logic                 up_meta,
    input  logic [BIM_IDX_W-1:0] up_idx_bim,
    input  logic [TAB_IDX_W-1:0] up_idx_g0,
    input  logic [TAB_IDX_W-1:0] up_idx_g1,
    input  logic [TAB_IDX_W-1:0] up_idx_meta
);
    logic [31:0] pc32, hist32;
    logic [BIM_IDX_W-1:0] ix_bim;
    logic [TAB_IDX_W-1:0] ix_g0, ix_g1, ix_meta;
    comp_bits_t rd, seen;
    upd_mode_e  m_bim, m_g0, m_g1, m_meta;
    logic       meta_dir;

    assign pc32    = 32'(lk_pc);
    assign hist32  = 32'(lk_hist);
    assign ix_bim  = BIM_IDX_W'(fold_index(pc32, hist32, BIM_HIST,  BIM_IDX_W));
    assign ix_g0   = TAB_IDX_W'(fold_index(pc32, hist32, G0_HIST,   TAB_IDX_W));
    assign ix_g1   = TAB_IDX_W'(fold_index(pc32, hist32, G1_HIST,   TAB_IDX_W));
    assign ix_meta = TAB_IDX_W'(fold_index(pc32, hist32, META_HIST, TAB_IDX_W));

    assign seen = '{bim: up_bim, g0: up_g0, g1: up_g1, meta: up_meta};

    bp_update_ctl u_ctl (
        .up_valid (up_valid), .up_taken (up_taken), .seen (seen),
        .mode_bim (m_bim), .mode_g0 (m_g0), .mode_g1 (m_g1),
        .mode_meta(m_meta), .meta_dir (meta_dir)
    );

    bp_table #(.IDX_W(BIM_IDX_W), .SHARE_LG(BIM_SHARE_LG)) u_bim (
        .clk(clk), .rst(rst), .rd_idx(ix_bim), .rd_bit(rd.bim),
        .up_mode(m_bim), .up_idx(up_idx_bim), .up_p(up_bim), .up_dir(up_taken));

    bp_table #(.IDX_W(TAB_IDX_W), .SHARE_LG(G0_SHARE_LG)) u_g0 (
        .clk(clk), .rst(rst), .rd_idx(ix_g0), .rd_bit(rd.g0),
        .up_mode(m_g0), .up_idx(up_idx_g0), .up_p(up_g0), .up_dir(up_taken));

    bp_table #(.IDX_W(TAB_IDX_W), .SHARE_LG(G1_SHARE_LG)) u_g1 (
        .clk(clk), .rst(rst), .rd_idx(ix_g1), .rd_bit(rd.g1),
        .up_mode(m_g1), .up_idx(up_idx_g1), .up_p(up_g1), .up_dir(up_taken));

    bp_table #(.IDX_W(TAB_IDX_W), .SHARE_LG(META_SHARE_LG)) u_meta (
        .clk(clk), .rst(rst), .rd_idx(ix_meta), .rd_bit(rd.meta),
        .up_mode(m_meta), .up_idx(up_idx_meta), .up_p(up_meta), .up_dir(meta_dir));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_taken    <= 1'b0;
            out_bim      <= 1'b0;
            out_g0       <= 1'b0;
            out_g1       <= 1'b0;
            out_meta     <= 1'b0;
            out_idx_bim  <= '0;
            out_idx_g0   <= '0;
            out_idx_g1   <= '0;
            out_idx_meta <= '0;
        end else begin
            out_valid <= lk_valid;
            if (lk_valid) begin
                out_taken    <= rd.meta ? majority3(rd.bim, rd.g0, rd.g1) : rd.bim;
                out_bim      <= rd.bim;
                out_g0       <= rd.g0;
                out_g1       <= rd.g1;
                out_meta     <= rd.meta;
                out_idx_bim  <= ix_bim;
                out_idx_g0   <= ix_g0;
                out_idx_g1   <= ix_g1;
                out_idx_meta <= ix_meta;
            end
        end
    end

    // R2: a result follows each accepted lookup
    a_r2_valid_after_lookup: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> out_valid);

    // R2: no result without a lookup
    a_r2_quiet_without_lookup: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !out_valid);

    // R4: with the chooser at 0 the final direction is the bimodal bit
    a_r4_bim_selected: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_meta) |-> out_taken == out_bim);

endmodule

// File: tb/skew_bp_test.sv
module skew_bp_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_pc = '0;
    logic [23:0] lk_hist = '0;
    logic        out_valid, out_taken, out_bim, out_g0, out_g1, out_meta;
    logic [5:0]  out_idx_bim;
    logic [7:0]  out_idx_g0, out_idx_g1, out_idx_meta;
    logic        up_valid = 1'b0, up_taken = 1'b0;
    logic        up_bim = 1'b0, up_g0 = 1'b0, up_g1 = 1'b0, up_meta = 1'b0;
    logic [5:0]  up_idx_bim = '0;
    logic [7:0]  up_idx_g0 = '0, up_idx_g1 = '0, up_idx_meta = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    skew_bp uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hist(lk_hist),
        .out_valid(out_valid), .out_taken(out_taken), .out_bim(out_bim),
        .out_g0(out_g0), .out_g1(out_g1), .out_meta(out_meta),
        .out_idx_bim(out_idx_bim), .out_idx_g0(out_idx_g0),
        .out_idx_g1(out_idx_g1), .out_idx_meta(out_idx_meta),
        .up_valid(up_valid), .up_taken(up_taken), .up_bim(up_bim), .up_g0(up_g0),
        .up_g1(up_g1), .up_meta(up_meta), .up_idx_bim(up_idx_bim),
        .up_idx_g0(up_idx_g0), .up_idx_g1(up_idx_g1), .up_idx_meta(up_idx_meta)
    );

    typedef struct packed {
        logic [15:0] pc;
        logic [23:0] hist;
        logic [7:0]  ib;
        logic [7:0]  ig0;
        logic [7:0]  ig1;
        logic [7:0]  im;
    } vec_t;

    // R3 index vectors, worked out by hand from the fold rule
    localparam vec_t VECS [8] = '{
        '{16'h0012, 24'h000000, 8'h12, 8'h12, 8'h12, 8'h12},
        '{16'h0012, 24'h000020, 8'h12, 8'h32, 8'h32, 8'h32},
        '{16'h0012, 24'h100000, 8'h12, 8'h12, 8'h02, 8'h12},
        '{16'h0012, 24'h010000, 8'h12, 8'h12, 8'h13, 8'h13},
        '{16'h0012, 24'h001000, 8'h12, 8'h02, 8'h02, 8'h02},
        '{16'h00FF, 24'h000008, 8'h37, 8'hF7, 8'hF7, 8'hF7},
        '{16'h0100, 24'h000101, 8'h01, 8'h00, 8'h00, 8'h00},
        '{16'h0000, 24'h1FFFFF, 8'h0F, 8'hE0, 8'h1F, 8'h01}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [15:0] pc, input logic [23:0] hist);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_pc    = pc;
        lk_hist  = hist;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_pred(input string req, input logic b, input logic g0,
                               input logic g1, input logic m, input logic t);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " bim"},   32'(out_bim),   32'(b));
        check({req, " g0"},    32'(out_g0),    32'(g0));
        check({req, " g1"},    32'(out_g1),    32'(g1));
        check({req, " meta"},  32'(out_meta),  32'(m));
        check({req, " taken"}, 32'(out_taken), 32'(t));
    endtask

    // all indices equal the address when history is zero (R3)
    task automatic update(input logic [7:0] ix, input logic b, input logic g0,
                          input logic g1, input logic m, input logic t);
        @(negedge clk);
        up_valid    = 1'b1;
        up_taken    = t;
        up_bim      = b;
        up_g0       = g0;
        up_g1       = g1;
        up_meta     = m;
        up_idx_bim  = ix[5:0];
        up_idx_g0   = ix;
        up_idx_g1   = ix;
        up_idx_meta = ix;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 valid low without lookup", 32'(out_valid), 32'd0);

        // R3 index folding and R1 reset contents
        for (int i = 0; i < 8; i++) begin
            lookup(VECS[i].pc, VECS[i].hist);
            check($sformatf("R3 bim idx v%0d", i),  32'(out_idx_bim),  32'(VECS[i].ib));
            check($sformatf("R3 g0 idx v%0d", i),   32'(out_idx_g0),   32'(VECS[i].ig0));
            check($sformatf("R3 g1 idx v%0d", i),   32'(out_idx_g1),   32'(VECS[i].ig1));
            check($sformatf("R3 meta idx v%0d", i), 32'(out_idx_meta), 32'(VECS[i].im));
            expect_pred("R1 reset state", 0, 0, 0, 0, 0);
        end
        @(negedge clk);
        check("R2 valid drops", 32'(out_valid), 32'd0);

        // R6 weak counters flip, R9 seen by next lookup
        lookup(16'h0021, 0);
        expect_pred("R1 fresh entry", 0, 0, 0, 0, 0);
        update(8'h21, 0, 0, 0, 0, 1);
        lookup(16'h0021, 0);
        expect_pred("R6 weak flip R9", 1, 1, 1, 0, 1);
        // R5 correct with bimodal chosen: only bimodal strengthened
        update(8'h21, 1, 1, 1, 0, 1);
        lookup(16'h0021, 0);
        expect_pred("R5 bits unchanged", 1, 1, 1, 0, 1);
        update(8'h21, 1, 1, 1, 0, 0);
        lookup(16'h0021, 0);
        expect_pred("R6 strong holds weak flips R5 partial", 1, 0, 0, 0, 1);
        // R7 disagreement with the majority right
        update(8'h21, 1, 0, 0, 0, 0);
        lookup(16'h0021, 0);
        expect_pred("R7 meta toward majority", 0, 0, 0, 1, 0);
        // R4 chooser selects the majority over the bimodal bit
        update(8'h21, 0, 0, 0, 1, 1);
        lookup(16'h0021, 0);
        expect_pred("R4 majority selected", 1, 0, 0, 1, 0);
        update(8'h21, 1, 0, 0, 1, 1);
        lookup(16'h0021, 0);
        expect_pred("R7 meta toward bimodal", 1, 1, 1, 0, 1);
        // R5 correct update claims meta 1: real meta bit must stay 0
        update(8'h21, 0, 1, 1, 1, 1);
        lookup(16'h0021, 0);
        expect_pred("R5 no pred write", 1, 1, 1, 0, 1);
        // R7 strengthened chooser only loses hysteresis
        update(8'h21, 1, 0, 0, 0, 0);
        lookup(16'h0021, 0);
        expect_pred("R7 strong meta holds", 1, 1, 1, 0, 1);

        // R8 shared hysteresis in G0 between entries 4 and 5
        update(8'h04, 0, 0, 0, 1, 0);
        update(8'h05, 0, 0, 0, 1, 1);
        lookup(16'h0005, 0);
        expect_pred("R8 shared g0 hysteresis", 1, 0, 1, 0, 1);
        lookup(16'h0004, 0);
        expect_pred("R8 neighbour pred kept", 0, 0, 0, 0, 0);
        update(8'h05, 0, 0, 0, 1, 1);
        lookup(16'h0005, 0);
        expect_pred("R8 g0 flips once weak", 1, 1, 1, 0, 1);
        lookup(16'h0004, 0);
        expect_pred("R8 neighbour still 0", 0, 0, 0, 0, 0);

        // R1 reset clears trained state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid low in second reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        lookup(16'h0021, 0);
        expect_pred("R1 cleared after reset", 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule